// File: doc/BRIEF.md
# Masked Register Instruction Executor

This block keeps a small local list of 32-byte instruction entries and, when asked, walks that list from the first entry to the last. For each entry whose action tag equals the requested action, it carries out one primitive operation on a register bus. The operations are a plain read, a read-and-compare, a write of a word supplied by software, a write of the entry's own constant, or nothing at all. Each operation is confined to a bit field of the target register. The field is placed by a bit offset, and its active bits are chosen by a 64-bit mask whose bit 0 lines up with the lowest bit of the field. A write may optionally keep all register bits outside the masked field by reading the register first and merging the new bits in.

Software first loads entries through a write port and then pulses `start` with an action code, a software data word and an entry count. The block raises `busy` and issues bus reads and writes with a simple request/acknowledge handshake. It finishes with a one-cycle `done` pulse, together with a status code, the last extracted field and the last compare outcome. An entry with an unknown opcode or an address space other than memory or I/O stops the walk at once and reports an invalid-access status.

The sequencer has seven states:

| State | Role |
|---|---|
| IDLE | Waits for `start`. With a count of zero it goes to FINISH; otherwise it goes to FETCH. |
| FETCH | Spends one cycle letting the local memory present the entry. |
| DECODE | Goes to NEXT on a tag mismatch or a no-op. Goes to FINISH on an illegal entry. Goes to READ for reads and preserving writes. Goes to WRITE for other writes. |
| READ | Holds a bus read until it is acknowledged. Then it goes to NEXT for reads, or to WRITE for a preserving write. |
| WRITE | Holds a bus write until it is acknowledged, then goes to NEXT. |
| NEXT | Goes to FINISH after the last entry; otherwise it advances the index and goes to FETCH. |
| FINISH | Pulses `done` and returns to IDLE. |

Top module: `emi_exec`

## Requirements
- R1: Entry layout is little-endian in 256 bits: action tag [7:0], opcode [15:8], flags [23:16], address space [39:32], bit offset [55:48], address [127:64], value [191:128], mask [255:192]. Only entries whose tag equals `req_action` run, strictly in index order. Entries with any other tag cause no bus access.
- R2: Opcode 0x00 reads the register. `rd_data` becomes (register >> offset) & mask.
- R3: Opcode 0x01 reads and extracts the field as in R2. It sets `cmp_true` to 1 when the field equals (value & mask) and to 0 otherwise, and also updates `rd_data`.
- R4: Opcode 0x02 writes ((sw_data & mask) << offset). The value field is not used.
- R5: Opcode 0x03 writes ((value & mask) << offset).
- R6: Flags bit 0 (preserve) makes a write read the register first. It then writes (old & ~(mask << offset)) | new bits. Without this flag, every bit outside the shifted mask is written as zero. For reads the flag is ignored, so exactly one bus read is made.
- R7: Opcode 0x04 makes no bus access and leaves `rd_data` and `cmp_true` unchanged.
- R8: A matching entry with an opcode above 0x04, or with an address space above 1, ends the run with status 2 (invalid access). It makes no bus access of its own, and later entries do not run. A run that ends normally reports status 0.
- R9: A count of zero gives `done` in the cycle after `start`, with status 0 and no bus access.
- R10: `busy` is high from the cycle after an accepted `start` until after `done`. `done` lasts one cycle. `start` is ignored while `busy` is high. `rd_data` and `cmp_true` clear to 0 when a run starts.
- R11: A bus request holds `bus_we`, `bus_space`, `bus_addr` and `bus_wdata` unchanged until `bus_ack`. `bus_space` is bit 0 of the entry's address space (0 memory, 1 I/O), and `bus_req` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_we | input | 1 | Write one entry into the local list |
| ent_waddr | input | IDX_W | Entry index to write |
| ent_wdata | input | 256 | Entry contents |
| start | input | 1 | Begin a run (accepted only when idle) |
| req_action | input | 8 | Action tag to select |
| sw_data | input | 64 | Software word for opcode 0x02 |
| num_entries | input | CNT_W | Number of entries in the list (clamped to DEPTH) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 success, 2 invalid access |
| rd_data | output | 64 | Last extracted field |
| cmp_true | output | 1 | Last compare outcome |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_space | output | 1 | 0 memory, 1 I/O |
| bus_addr | output | 64 | Register address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` |

## Verification
On every cycle, the assertions check the following:
- the bus request holds steady until it is acknowledged, and the bus is never requested outside a run;
- `done` is a single-cycle pulse that carries only a legal status code;
- an empty list finishes in the cycle after `start`.

Only the bench scenarios can show the field arithmetic: the extraction, the compare outcome and the exact merged write word. The same holds for the order and count of bus transfers under tag filtering, the single extra read that a preserving write adds, and the way an illegal entry cuts off the entries behind it. The bench predicts each of these from a behavioural model of the register contents and compares every bus transfer as it is acknowledged.

// File: rtl/emi_pkg.sv
package emi_pkg;

    localparam int ENTRY_BITS = 256;
    localparam int WORD_BITS  = 64;

    localparam logic [7:0] OP_READ     = 8'h00;
    localparam logic [7:0] OP_READ_CMP = 8'h01;
    localparam logic [7:0] OP_WRITE_SW = 8'h02;
    localparam logic [7:0] OP_WRITE_K  = 8'h03;
    localparam logic [7:0] OP_NOOP     = 8'h04;

    localparam logic [7:0] SPACE_IO    = 8'h01;

    localparam logic [1:0] STS_OK      = 2'd0;
    localparam logic [1:0] STS_INVALID = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_READ,
        ST_WRITE,
        ST_NEXT,
        ST_FINISH
    } emi_state_e;

    typedef struct packed {
        logic [63:0] mask;
        logic [63:0] value;
        logic [63:0] address;
        logic [7:0]  access_size;
        logic [7:0]  bit_offset;
        logic [7:0]  bit_width;
        logic [7:0]  space_id;
        logic [7:0]  rsvd;
        logic [7:0]  flags;
        logic [7:0]  instr;
        logic [7:0]  action;
    } emi_entry_t;

endpackage

// File: rtl/emi_entry_ram.sv
module emi_entry_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/emi_field_unit.sv
module emi_field_unit
    import emi_pkg::*;
#(
    parameter int W = WORD_BITS
) (
    input  logic [W-1:0] reg_word,
    input  logic [W-1:0] old_word,
    input  logic [W-1:0] sw_word,
    input  emi_entry_t   ent,
    output logic [W-1:0] field_val,
    output logic [W-1:0] write_word
);

    logic [W-1:0] src;
    logic [W-1:0] ins_bits;
    logic [W-1:0] pos_mask;

    always_comb begin
        field_val  = (reg_word >> ent.bit_offset) & ent.mask;
        src        = (ent.instr == OP_WRITE_SW) ? sw_word : ent.value;
        ins_bits   = (src & ent.mask) << ent.bit_offset;
        pos_mask   = ent.mask << ent.bit_offset;
        write_word = ent.flags[0] ? ((old_word & ~pos_mask) | ins_bits) : ins_bits;
    end

endmodule

// File: rtl/emi_seq_fsm.sv
module emi_seq_fsm
    import emi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [7:0]           req_action,
    input  logic [WORD_BITS-1:0] sw_data,
    input  logic [CNT_W-1:0]     num_entries,
    input  emi_entry_t           ent,
    input  logic [WORD_BITS-1:0] field_val,
    input  logic [WORD_BITS-1:0] write_word,
    input  logic                 bus_ack,
    input  logic [WORD_BITS-1:0] bus_rdata,
    output logic [IDX_W-1:0]     ent_idx,
    output logic [WORD_BITS-1:0] sw_word,
    output logic [WORD_BITS-1:0] old_word,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           status,
    output logic [WORD_BITS-1:0] rd_data,
    output logic                 cmp_true,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic                 bus_space,
    output logic [WORD_BITS-1:0] bus_addr,
    output logic [WORD_BITS-1:0] bus_wdata
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    emi_state_e           state, nxt;
    logic [CNT_W-1:0]     cnt_q;
    logic [7:0]           act_q;
    logic [1:0]           status_q;
    logic [WORD_BITS-1:0] rd_q;
    logic                 cmp_q;
    logic                 is_read_op;
    logic                 bad_entry;
    logic                 needs_read;
    logic                 tag_hit;
    logic                 last_entry;

    always_comb begin
        is_read_op = (ent.instr == OP_READ) || (ent.instr == OP_READ_CMP);
        bad_entry  = (ent.instr > OP_NOOP) || (ent.space_id > SPACE_IO);
        needs_read = is_read_op || ent.flags[0];
        tag_hit    = (ent.action == act_q);
        last_entry = (CNT_W'(ent_idx) == (cnt_q - CNT_W'(1)));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt = (num_entries == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (!tag_hit) begin
                    nxt = ST_NEXT;
                end else if (bad_entry) begin
                    nxt = ST_FINISH;
                end else if (ent.instr == OP_NOOP) begin
                    nxt = ST_NEXT;
                end else if (needs_read) begin
                    nxt = ST_READ;
                end else begin
                    nxt = ST_WRITE;
                end
            end
            ST_READ: begin
                if (bus_ack) begin
                    nxt = is_read_op ? ST_NEXT : ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (bus_ack) begin
                    nxt = ST_NEXT;
                end
            end
            ST_NEXT:   nxt = last_entry ? ST_FINISH : ST_FETCH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Run context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_q    <= '0;
            sw_word  <= '0;
            ent_idx  <= '0;
            status_q <= STS_OK;
            rd_q     <= '0;
            cmp_q    <= 1'b0;
            old_word <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q    <= (num_entries > DEPTH_C) ? DEPTH_C : num_entries;
                        act_q    <= req_action;
                        sw_word  <= sw_data;
                        ent_idx  <= '0;
                        status_q <= STS_OK;
                        rd_q     <= '0;
                        cmp_q    <= 1'b0;
                    end
                end
                ST_DECODE: begin
                    if (tag_hit && bad_entry) begin
                        status_q <= STS_INVALID;
                    end
                end
                ST_READ: begin
                    if (bus_ack) begin
                        if (is_read_op) begin
                            rd_q <= field_val;
                            if (ent.instr == OP_READ_CMP) begin
                                cmp_q <= (field_val == (ent.value & ent.mask));
                            end
                        end else begin
                            old_word <= bus_rdata;
                        end
                    end
                end
                ST_NEXT: begin
                    if (!last_entry) begin
                        ent_idx <= ent_idx + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        status    = status_q;
        rd_data   = rd_q;
        cmp_true  = cmp_q;
        bus_req   = (state == ST_READ) || (state == ST_WRITE);
        bus_we    = (state == ST_WRITE);
        bus_space = ent.space_id[0];
        bus_addr  = ent.address;
        bus_wdata = (state == ST_WRITE) ? write_word : '0;
    end

endmodule

// File: rtl/emi_exec.sv
module emi_exec
    import emi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ent_we,
    input  logic [IDX_W-1:0]      ent_waddr,
    input  logic [ENTRY_BITS-1:0] ent_wdata,
    input  logic                  start,
    input  logic [7:0]            req_action,
    input  logic [WORD_BITS-1:0]  sw_data,
    input  logic [CNT_W-1:0]      num_entries,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            status,
    output logic [WORD_BITS-1:0]  rd_data,
    output logic                  cmp_true,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic                  bus_space,
    output logic [WORD_BITS-1:0]  bus_addr,
    output logic [WORD_BITS-1:0]  bus_wdata,
    input  logic                  bus_ack,
    input  logic [WORD_BITS-1:0]  bus_rdata
);

    logic [IDX_W-1:0]      rd_idx;
    logic [ENTRY_BITS-1:0] ent_raw;
    emi_entry_t            ent;
    logic [WORD_BITS-1:0]  field_val;
    logic [WORD_BITS-1:0]  write_word;
    logic [WORD_BITS-1:0]  sw_word;
    logic [WORD_BITS-1:0]  old_word;

    assign ent = emi_entry_t'(ent_raw);

    emi_entry_ram #(
        .DEPTH(DEPTH),
        .WIDTH(ENTRY_BITS)
    ) u_ram (
        .clk  (clk),
        .we   (ent_we),
        .waddr(ent_waddr),
        .wdata(ent_wdata),
        .raddr(rd_idx),
        .rdata(ent_raw)
    );

    emi_field_unit #(
        .W(WORD_BITS)
    ) u_field (
        .reg_word  (bus_rdata),
        .old_word  (old_word),
        .sw_word   (sw_word),
        .ent       (ent),
        .field_val (field_val),
        .write_word(write_word)
    );

    emi_seq_fsm #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_action (req_action),
        .sw_data    (sw_data),
        .num_entries(num_entries),
        .ent        (ent),
        .field_val  (field_val),
        .write_word (write_word),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .ent_idx    (rd_idx),
        .sw_word    (sw_word),
        .old_word   (old_word),
        .busy       (busy),
        .done       (done),
        .status     (status),
        .rd_data    (rd_data),
        .cmp_true   (cmp_true),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_space  (bus_space),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata)
    );

endmodule

// File: rtl/emi_exec_chk.sv
module emi_exec_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] num_entries,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_space,
    input logic [63:0]      bus_addr,
    input logic [63:0]      bus_wdata,
    input logic             bus_ack
);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_space)
                                   && $stable(bus_addr) && $stable(bus_wdata)));

    assert_bus_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_empty_list_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (num_entries == '0)) |=> (done && (status == 2'd0)));

    assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((status == 2'd0) || (status == 2'd2)));

endmodule

bind emi_exec emi_exec_chk #(.CNT_W(CNT_W)) u_emi_exec_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .num_entries(num_entries),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_space  (bus_space),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack)
);

// File: tb/emi_exec_bench.sv
module emi_exec_bench;

    localparam int DEPTH = 16;
    localparam int IDX_W = 4;
    localparam int CNT_W = 5;

    typedef struct {
        bit          we;
        bit          sp;
        logic [63:0] a;
        logic [63:0] d;
    } txn_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ent_we = 1'b0;
    logic [IDX_W-1:0]  ent_waddr = '0;
    logic [255:0]      ent_wdata = '0;
    logic              start = 1'b0;
    logic [7:0]        req_action = '0;
    logic [63:0]       sw_data = '0;
    logic [CNT_W-1:0]  num_entries = '0;
    logic              busy, done, cmp_true;
    logic [1:0]        status;
    logic [63:0]       rd_data;
    logic              bus_req, bus_we, bus_space;
    logic [63:0]       bus_addr, bus_wdata;
    logic              bus_ack = 1'b0;
    logic [63:0]       bus_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int waitc = 0;
    int txn_no = 0;

    logic [255:0] tbl [DEPTH];
    logic [63:0]  sregs [logic [64:0]];
    logic [63:0]  mregs [logic [64:0]];
    txn_t         expq [$];

    always #5 clk = ~clk;

    emi_exec #(.DEPTH(DEPTH)) u_emi_exec (
        .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_waddr(ent_waddr),
        .ent_wdata(ent_wdata), .start(start), .req_action(req_action),
        .sw_data(sw_data), .num_entries(num_entries), .busy(busy), .done(done),
        .status(status), .rd_data(rd_data), .cmp_true(cmp_true),
        .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] mk(input logic [7:0] act, input logic [7:0] op,
                                        input logic [7:0] fl, input logic [7:0] sp,
                                        input logic [7:0] off, input logic [63:0] ad,
                                        input logic [63:0] val, input logic [63:0] msk);
        return {msk, val, ad, 8'h03, off, 8'h40, sp, 8'h00, fl, op, act};
    endfunction

    // Bus responder, with every transfer compared against the model's prediction (R1, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(bus_req && !busy), "R11 bus request outside run", 64'(bus_req), 64'd0);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (waitc >= (txn_no % 3)) begin
                    waitc = 0;
                    txn_no++;
                    bus_ack = 1'b1;
                    bus_rdata = sregs.exists({bus_space, bus_addr}) ? sregs[{bus_space, bus_addr}] : 64'd0;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R1 unexpected bus transfer", bus_addr, 64'd0);
                    end else begin
                        txn_t e;
                        e = expq.pop_front();
                        chk(bus_we == e.we, "R1 transfer direction", 64'(bus_we), 64'(e.we));
                        chk(bus_space == e.sp, "R11 transfer space", 64'(bus_space), 64'(e.sp));
                        chk(bus_addr == e.a, "R1 transfer address", bus_addr, e.a);
                        if (e.we) begin
                            chk(bus_wdata == e.d, "R4/R5/R6 write word", bus_wdata, e.d);
                        end
                    end
                    if (bus_we) begin
                        sregs[{bus_space, bus_addr}] = bus_wdata;
                    end
                end else begin
                    waitc++;
                end
            end
        end
    end

    task automatic set_reg(input bit sp, input logic [63:0] a, input logic [63:0] v);
        sregs[{sp, a}] = v;
        mregs[{sp, a}] = v;
    endtask

    task automatic load(input int i, input logic [255:0] e);
        @(negedge clk);
        ent_we = 1'b1;
        ent_waddr = IDX_W'(i);
        ent_wdata = e;
        tbl[i] = e;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic model(input logic [7:0] a, input logic [63:0] sw, input int n,
                         output logic [63:0] rd, output bit cmp, output logic [1:0] st);
        rd = '0; cmp = 1'b0; st = 2'd0;
        for (int i = 0; i < n; i++) begin
            logic [255:0] e;
            logic [7:0] op, fl, sp, off;
            logic [63:0] ad, val, msk, cur, f, src, nw;
            txn_t t;
            e = tbl[i];
            op = e[15:8]; fl = e[23:16]; sp = e[39:32]; off = e[55:48];
            ad = e[127:64]; val = e[191:128]; msk = e[255:192];
            if (e[7:0] != a) continue;
            if (op > 8'h04 || sp > 8'h01) begin
                st = 2'd2;
                break;
            end
            if (op == 8'h04) continue;
            cur = mregs.exists({sp[0], ad}) ? mregs[{sp[0], ad}] : 64'd0;
            if (op <= 8'h01) begin
                t.we = 0; t.sp = sp[0]; t.a = ad; t.d = '0; expq.push_back(t);
                f = (cur >> off) & msk;
                rd = f;
                if (op == 8'h01) cmp = (f == (val & msk));
            end else begin
                src = (op == 8'h02) ? sw : val;
                nw = (src & msk) << off;
                if (fl[0]) begin
                    t.we = 0; t.sp = sp[0]; t.a = ad; t.d = '0; expq.push_back(t);
                    nw = (cur & ~(msk << off)) | nw;
                end
                t.we = 1; t.sp = sp[0]; t.a = ad; t.d = nw; expq.push_back(t);
                mregs[{sp[0], ad}] = nw;
            end
        end
    endtask

    task automatic run(input string tag, input logic [7:0] a, input logic [63:0] sw,
                       input int n);
        logic [63:0] erd;
        bit ecmp;
        logic [1:0] est;
        int guard;
        model(a, sw, n, erd, ecmp, est);
        @(negedge clk);
        req_action = a; sw_data = sw; num_entries = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        if (n == 0) begin
            start = 1'b0;
            chk(done == 1'b1, {tag, " R9 done one cycle after start"}, 64'(done), 64'd1);
        end else begin
            // R10: start held while busy must not restart the run
            chk(busy == 1'b1, {tag, " R10 busy after start"}, 64'(busy), 64'd1);
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 500, {tag, " R10 run completes"}, 64'(guard), 64'd0);
        chk(status == est, {tag, " status"}, 64'(status), 64'(est));
        chk(rd_data == erd, {tag, " rd_data"}, rd_data, erd);
        chk(cmp_true == ecmp, {tag, " cmp_true"}, 64'(cmp_true), 64'(ecmp));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " R10 done single pulse"}, 64'({done, busy}), 64'd0);
        chk(expq.size() == 0, {tag, " all predicted transfers seen"}, 64'(expq.size()), 64'd0);
        expq.delete();
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        set_reg(1'b0, 64'h1000, 64'h0000_0000_0000_00D6);
        set_reg(1'b1, 64'h0080, 64'hFFFF_FFFF_FFFF_FFFF);
        set_reg(1'b0, 64'h2000, 64'h1234_5678_9ABC_DEF0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && bus_req == 1'b0, "reset outputs idle",
            64'({busy, done, bus_req}), 64'd0);
        rst_n = 1'b1;
        chk(status == 2'd0 && rd_data == '0, "reset status and data", rd_data, 64'd0);

        load(0,  mk(8'h03, 8'h00, 8'h00, 8'h00, 8'd2, 64'h1000, 64'h0, 64'h1B));
        load(1,  mk(8'h07, 8'h01, 8'h00, 8'h00, 8'd2, 64'h1000, 64'h11, 64'h1B));
        load(2,  mk(8'h05, 8'h02, 8'h00, 8'h01, 8'd4, 64'h0080, 64'hDEAD, 64'hF));
        load(3,  mk(8'h05, 8'h03, 8'h01, 8'h00, 8'd8, 64'h2000, 64'hAB, 64'hFF));
        load(4,  mk(8'h05, 8'h04, 8'h00, 8'h00, 8'd0, 64'h1000, 64'h0, 64'hFF));
        load(5,  mk(8'h02, 8'h01, 8'h00, 8'h00, 8'd8, 64'h2000, 64'h1AB, 64'hFF));
        load(6,  mk(8'h09, 8'h07, 8'h00, 8'h00, 8'd0, 64'h1000, 64'h0, 64'hFF));
        load(7,  mk(8'h09, 8'h00, 8'h00, 8'h00, 8'd0, 64'h1000, 64'h0, 64'hFF));
        load(8,  mk(8'h0A, 8'h00, 8'h00, 8'h02, 8'd0, 64'h1000, 64'h0, 64'hFF));
        load(9,  mk(8'h05, 8'h00, 8'h00, 8'h01, 8'd0, 64'h0080, 64'h0, 64'hFFFF));
        load(10, mk(8'h03, 8'h00, 8'h01, 8'h00, 8'd1, 64'h2000, 64'h0, 64'h7));

        run("R9 empty list",                  8'h03, 64'h0, 0);
        run("R2 R6 reads, preserve ignored",  8'h03, 64'h0, 11);
        run("R3 compare true",                8'h07, 64'h0, 11);
        run("R3 compare false",               8'h02, 64'h0, 11);
        run("R4 R5 R6 R7 writes and noop",    8'h05, 64'h0000_0000_0000_005A, 11);
        run("R3 compare after write",         8'h02, 64'h0, 11);
        run("R8 bad opcode aborts",           8'h09, 64'h0, 11);
        run("R8 bad space aborts",            8'h0A, 64'h0, 11);
        run("R2 first entry only",            8'h03, 64'h0, 1);
        run("R1 no entry matches",            8'h42, 64'h0, 11);
        run("R4 second software word",        8'h05, 64'hFFFF_FFFF_FFFF_FFF3, 11);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule